// File: doc/BRIEF.md
# Staged Multichannel Attenuation Register Bank

This block keeps the digital attenuation settings for a multichannel audio output path made of several stereo converter pairs. Each channel has an 8-bit code, and one code step is 0.5 dB of attenuation. The all-ones code means 0 dB, so it passes the signal unchanged. Writes come in on a plain address/data strobe port, usually from a control-interface decoder. The downstream gain stage reads the active codes from a flat output bus.

Each write to a channel address loads only a staging latch for that channel. Bit 8 of the write word is an update flag, and it is never stored. When the flag is set, every channel's staged value moves into its active register in the same clock edge. The addressed channel takes the new data from that same write. This lets software change all gains together, without a period where some channels carry new gains and others old ones. A one-cycle strobe marks each transfer, so a downstream ramp or re-sampling stage can follow it.

Top module: `attnBank`

## Requirements
- R1: A synchronous active-high reset sets every staging latch and every active code to 0xFF and clears the commit strobe.
- R2: Channel k sits at address 0x09 + k. Channels 0 to 7 therefore use addresses 0x09 to 0x10. An even k is the left channel and an odd k is the right channel of pair k/2. The active code of channel k appears on `activeCodes[8k+7:8k]`.
- R3: An accepted write with `wrData[8]` = 0 stores `wrData[7:0]` in the addressed channel's staging latch only. It leaves all active codes unchanged and raises no strobe.
- R4: An accepted write with `wrData[8]` = 1 copies every channel's staged value into its active register at that clock edge. The addressed channel receives the new `wrData[7:0]`, not its earlier staged value.
- R5: `commitPulse` is high for exactly the one cycle after each clock edge that accepts a committing write. Back-to-back committing writes give a strobe in each cycle.
- R6: A write whose address lies outside 0x09..0x10 changes no staging latch and no active code, and raises no strobe, even when bit 8 is set.
- R7: Active codes change only on a committing write or on reset.
- R8: The update flag is not stored. A committed code equals `wrData[7:0]`, including the value 0x00.
- R9: With `wrEn` low the inputs are ignored, whatever the address and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | 5 | Register address |
| wrData | input | 9 | Bit 8 update flag, bits 7:0 attenuation code |
| activeCodes | output | 64 | Active code of channel k in bits 8k+7:8k |
| commitPulse | output | 1 | One-cycle strobe after each transfer |

## Verification
The assertions assume that the write inputs are known and stable at every rising edge. They also assume that reset is held for at least two edges, so that the stability check starts from defined codes. The bench changes the inputs only on falling edges. It holds reset for two cycles, and it drives address and data to defined values even while `wrEn` is low. It exercises addresses just below and just above the channel range, a high unused address, ignored writes with the flag set, and consecutive committing writes.

// File: rtl/attnBankPkg.sv
package attnBankPkg;
  localparam int CH_IDX_W = 4;

  typedef struct packed {
    logic stage;
    logic commit;
    logic [CH_IDX_W-1:0] chan;
  } attnCtrl_t;
endpackage

// File: rtl/attnCtrl.sv
module attnCtrl
  import attnBankPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h09,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrFlag,
  output attnCtrl_t         ctrl,
  output logic              commitPulse
);
  logic [ADDR_W-1:0] offset;
  logic              inRange;

  // Wrapping subtraction: addresses below the base become large and fall out of range.
  assign offset  = wrAddr - BASE_ADDR;
  assign inRange = offset < ADDR_W'(NUM_CH);

  always_comb begin
    ctrl.stage  = wrEn && inRange;
    ctrl.commit = wrEn && inRange && wrFlag;
    ctrl.chan   = CH_IDX_W'(offset);
  end

  always_ff @(posedge clk) begin
    if (rst) commitPulse <= 1'b0;
    else     commitPulse <= ctrl.commit;
  end
endmodule

// File: rtl/attnDatapath.sv
module attnDatapath
  import attnBankPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  attnCtrl_t                ctrl,
  input  logic [CODE_W-1:0]        wrCode,
  output logic [NUM_CH*CODE_W-1:0] activeCodes
);
  localparam logic [CODE_W-1:0] RESET_CODE = {CODE_W{1'b1}};

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic [CODE_W-1:0] stagedCode;
    logic [CODE_W-1:0] liveCode;
    logic              hit;

    assign hit = ctrl.stage && (ctrl.chan == CH_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        stagedCode <= RESET_CODE;
        liveCode   <= RESET_CODE;
      end else begin
        if (hit) stagedCode <= wrCode;
        if (ctrl.commit) liveCode <= hit ? wrCode : stagedCode;
      end
    end

    assign activeCodes[i*CODE_W +: CODE_W] = liveCode;
  end
endmodule

// File: rtl/attnBank.sv
module attnBank
  import attnBankPkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h09
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [CODE_W:0]              wrData,
  output logic [2*NUM_PAIRS*CODE_W-1:0] activeCodes,
  output logic                         commitPulse
);
  localparam int NUM_CH = 2 * NUM_PAIRS;

  attnCtrl_t ctrl;

  attnCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrFlag(wrData[CODE_W]), .ctrl(ctrl), .commitPulse(commitPulse)
  );

  attnDatapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) uData (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .wrCode(wrData[CODE_W-1:0]), .activeCodes(activeCodes)
  );
endmodule

// File: rtl/attnBankChecker.sv
module attnBankChecker #(
  parameter int NUM_PAIRS = 4,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h09
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wrEn,
  input logic [ADDR_W-1:0]             wrAddr,
  input logic [CODE_W:0]               wrData,
  input logic [2*NUM_PAIRS*CODE_W-1:0] activeCodes,
  input logic                          commitPulse
);
  localparam int NUM_CH = 2 * NUM_PAIRS;

  logic [ADDR_W-1:0] chanIdx;
  logic              commitWrite;

  assign chanIdx     = wrAddr - BASE_ADDR;
  assign commitWrite = wrEn && (chanIdx < ADDR_W'(NUM_CH)) && wrData[CODE_W];

  function automatic logic [CODE_W-1:0] codeOf(
    input logic [2*NUM_PAIRS*CODE_W-1:0] vec, input logic [ADDR_W-1:0] idx);
    return CODE_W'(vec >> (CODE_W * idx));
  endfunction

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (activeCodes == '1 && !commitPulse));

  assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    commitWrite |=> commitPulse);

  assert_no_spurious_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    !commitWrite |=> !commitPulse);

  assert_addressed_new_data_R4: assert property (@(posedge clk) disable iff (rst)
    commitWrite |=> codeOf(activeCodes, $past(chanIdx)) == $past(wrData[CODE_W-1:0]));

  assert_active_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !commitPulse |-> $stable(activeCodes));
endmodule

bind attnBank attnBankChecker #(
  .NUM_PAIRS(NUM_PAIRS), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) uChecker (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .activeCodes(activeCodes), .commitPulse(commitPulse)
);

// File: tb/tb_attnBank.sv
module tb_attnBank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [8:0]  wrData = '0;
  logic [63:0] activeCodes;
  logic        commitPulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] stg [NCH];
  logic [7:0] act [NCH];

  logic [63:0] expAct [$];
  logic        expPulse [$];
  string       expTag [$];

  attnBank dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .activeCodes(activeCodes), .commitPulse(commitPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] packAct();
    logic [63:0] v;
    for (int i = 0; i < NCH; i++) v[i*8 +: 8] = act[i];
    return v;
  endfunction

  task automatic pushExp(input logic p, input string tag);
    expAct.push_back(packAct());
    expPulse.push_back(p);
    expTag.push_back(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    wrEn = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      stg[i] = 8'hFF;
      act[i] = 8'hFF;
    end
    pushExp(1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: one write per call, model derived from the requirements.
  task automatic doWrite(input logic en, input logic [4:0] a, input logic [8:0] d,
                         input string tag);
    int idx;
    logic p;
    wrEn = en;
    wrAddr = a;
    wrData = d;
    @(posedge clk);
    p = 1'b0;
    idx = int'(a) - 9;
    if (en && idx >= 0 && idx < NCH) begin
      stg[idx] = d[7:0];
      if (d[8]) begin
        for (int i = 0; i < NCH; i++) act[i] = stg[i];
        p = 1'b1;
      end
    end
    pushExp(p, tag);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Monitor: compares each expected item in the cycle it belongs to.
  always @(negedge clk) begin
    if (expAct.size() > 0) begin
      logic [63:0] ea;
      logic ep;
      string t;
      ea = expAct.pop_front();
      ep = expPulse.pop_front();
      t = expTag.pop_front();
      total++;
      if (activeCodes !== ea || commitPulse !== ep) begin
        bad++;
        $display("FAIL %s: activeCodes=%h commitPulse=%b expected activeCodes=%h commitPulse=%b",
                 t, activeCodes, commitPulse, ea, ep);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();                                            // R1
    doWrite(1, 5'h09, 9'h010, "R3");                      // stage ch0 only
    doWrite(1, 5'h10, 9'h022, "R3");                      // stage ch7 only
    doWrite(1, 5'h0C, 9'h155, "R4");                      // commit, ch3 new data
    doWrite(0, 5'h09, 9'h000, "R5");                      // idle: strobe drops
    doWrite(1, 5'h08, 9'h1AA, "R6");                      // just below range
    doWrite(1, 5'h11, 9'h1BB, "R6");                      // just above range
    doWrite(1, 5'h1F, 9'h0CC, "R6");                      // high unused address
    doWrite(0, 5'h0A, 9'h177, "R9");                      // disabled commit write
    doWrite(1, 5'h0A, 9'h101, "R6");                      // commit: ch0 still 0x10
    for (int i = 0; i < NCH; i++)                         // R2 address map
      doWrite(1, 5'(9 + i), 9'({1'b0, 8'(i * 17 + 3)}), "R2");
    doWrite(1, 5'h09, 9'h1FE, "R2");                      // commit with ch0 new
    doWrite(1, 5'h0E, 9'h100, "R8");                      // code 0x00 committed
    doWrite(1, 5'h0F, 9'h140, "R5");                      // back-to-back commit
    doWrite(1, 5'h10, 9'h133, "R5");
    doWrite(0, 5'h10, 9'h000, "R7");                      // hold after commits
    doWrite(1, 5'h0B, 9'h044, "R7");                      // stage, no change
    doReset();                                            // R1 mid-run
    doWrite(1, 5'h0D, 9'h166, "R4");                      // only ch4 differs
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule